// File: doc/BRIEF.md
# Saturating Counting Semaphore Cell

This block is a single hardware counting semaphore that several requesters share through one access port. A requester signals V, or "release", by writing through one of the semaphore views. The cell adds one to its count, stopping at the largest value the count register can hold. A requester signals P, or "acquire", by reading through a semaphore view. The read returns the count as it stood before the access, and the cell takes one from the count if the count was above zero.

There are two semaphore views, which differ only in what happens at zero. A waiting read at zero raises a stall in the same cycle, leaves the count unchanged and records the requester's ID in a mask of blocked requesters. A polling read at zero simply returns zero. The next semaphore write pulses a wake vector carrying every recorded ID for one cycle and empties the mask. Woken requesters then retry.

A raw view reads the count without changing it and ignores writes. A tag view reads and loads three status flags. The cell sits behind an address decoder that supplies the view code.

Top module: `sem_cell`

## Requirements
- R1: A read through view code 4 (waiting) or 5 (polling) that does not stall loads `rd_data` at the next clock edge with the count as it was before the access, zero-extended.
- R2: A semaphore read lowers the count by one only when the count is above zero; at zero the count stays zero.
- R3: A view-4 read at count zero drives `stall` high in the same cycle, leaves the count and `rd_data` unchanged, and records `acc_id` in the blocked mask. A view-5 read at zero returns 0 and keeps `stall` low.
- R4: A write through view 4 or 5 ignores `acc_wdata` and raises the count by one, saturating at 2^CNT_W-1 (0xFFFF by default) without wrapping.
- R5: When blocked requesters are recorded, a view-4/5 write drives `wake_vec` for exactly one cycle after the next edge, with bit i set for each recorded ID i, and then empties the mask. Any other access leaves `wake_vec` at zero in the following cycle.
- R6: A view-0 (raw) read returns the count zero-extended and does not change it. A view-0 write has no effect.
- R7: After reset the count is 0, all tag flags are 0, and `rd_data`, `stall` and `wake_vec` are all 0.
- R8: A view-1 (tag) read returns the empty flag in bit 0, the full flag in bit 1 and the general flag in bit 16. Every other bit reads as 0, including bit 17, the queue-mode flag, which is always 0 in this cell. A view-1 write loads the three flags from those same bit positions and leaves the count unchanged.
- R9: When `acc_rd` and `acc_wr` are both high in one cycle, only the write takes effect. The read neither stalls nor updates `rd_data`.
- R10: A nonzero `wake_vec` appears in the same cycle as the incremented count, so a woken requester that retries at once sees the new count.
- R11: Reads through view codes 2, 3, 6 and 7 return 0, and writes through those codes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_rd | input | 1 | Read strobe for the current access |
| acc_wr | input | 1 | Write strobe for the current access |
| acc_view | input | 3 | View code (0 raw, 1 tag, 4 waiting semaphore, 5 polling semaphore) |
| acc_id | input | ID_W | ID of the requester making the access |
| acc_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read result |
| stall | output | 1 | A waiting read found the count at zero |
| wake_vec | output | N_REQ | One-cycle pulse of woken requester IDs |

## Verification
The case hardest to reach from the ports is saturation. Making the count reach its ceiling takes one release write per unit of count. The bench therefore issues 65535 back-to-back semaphore writes, writes again to confirm the count holds at the ceiling, and then reads to confirm that the decrement starts from the ceiling. The bench also stacks two blocked requesters before a single release. It checks the wake pulse in its one-cycle window, then retries a read in that same cycle to confirm that the new count is already visible.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

  typedef enum logic [2:0] {
    VW_RAW   = 3'd0,
    VW_TAG   = 3'd1,
    VW_QSYNC = 3'd2,
    VW_QTRY  = 3'd3,
    VW_WAIT  = 3'd4,
    VW_POLL  = 3'd5
  } sem_view_e;

  localparam int TAG_E_BIT = 0;
  localparam int TAG_F_BIT = 1;
  localparam int TAG_T_BIT = 16;
  localparam int TAG_Q_BIT = 17;

  typedef struct packed {
    logic sem_rd_wait;
    logic sem_rd_poll;
    logic sem_wr;
    logic raw_rd;
    logic tag_rd;
    logic tag_wr;
    logic null_rd;
  } sem_op_t;

endpackage

// File: rtl/sem_view_decode.sv
module sem_view_decode
  import sem_cell_pkg::*;
(
  input  logic       rd,
  input  logic       wr,
  input  logic [2:0] view,
  output sem_op_t    op
);

  logic rd_eff;

  // write wins when both strobes are present (R9)
  assign rd_eff = rd & ~wr;

  always_comb begin
    op = '0;
    case (view)
      VW_RAW: begin
        op.raw_rd = rd_eff;
      end
      VW_TAG: begin
        op.tag_rd = rd_eff;
        op.tag_wr = wr;
      end
      VW_WAIT: begin
        op.sem_rd_wait = rd_eff;
        op.sem_wr      = wr;
      end
      VW_POLL: begin
        op.sem_rd_poll = rd_eff;
        op.sem_wr      = wr;
      end
      default: begin
        op.null_rd = rd_eff;
      end
    endcase
  end

endmodule

// File: rtl/sem_count_core.sv
module sem_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_req,
  input  logic             dec_req,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             inc_ok, dec_ok;

  always_comb begin
    inc_ok = inc_req && (cnt_q != CNT_MAX);
    dec_ok = dec_req && (cnt_q != '0);
    cnt_en = inc_ok || dec_ok;
    cnt_d  = inc_ok ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign cnt_zero = (cnt_q == '0);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && !dec_req && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !inc_req && cnt_q == '0) |=> (cnt_q == '0)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !inc_req && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2

endmodule

// File: rtl/sem_wait_tracker.sv
module sem_wait_tracker #(
  parameter int N_REQ = 8,
  parameter int ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             block_req,
  input  logic [ID_W-1:0]  block_id,
  input  logic             wake_req,
  output logic [N_REQ-1:0] wake_vec
);

  logic [N_REQ-1:0] mask_q, mask_d;
  logic             mask_en;
  logic [N_REQ-1:0] wake_q, wake_d;

  always_comb begin
    mask_en = wake_req || block_req;
    if (wake_req) mask_d = '0;
    else          mask_d = mask_q | (N_REQ'(1) << block_id);
    wake_d = wake_req ? mask_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= '0;
    else        wake_q <= wake_d;
  end

  assign wake_vec = wake_q;

  AST_WAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q != '0) |-> (mask_q == '0)); // R5
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q != '0) |=> (wake_q == '0)); // R5
  AST_BLOCK_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (block_req && !wake_req) |=> mask_q[$past(block_id)]); // R3

endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_cell_pkg::*;
#(
  parameter int   CNT_W  = 16,
  parameter int   DATA_W = 32,
  parameter int   N_REQ  = 8,
  localparam int  ID_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [2:0]        acc_view,
  input  logic [ID_W-1:0]   acc_id,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              stall,
  output logic [N_REQ-1:0]  wake_vec
);

  localparam logic [DATA_W-1:0] TAG_MASK =
    (DATA_W'(1) << TAG_E_BIT) | (DATA_W'(1) << TAG_F_BIT) | (DATA_W'(1) << TAG_T_BIT);

  sem_op_t           op;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_zero;
  logic              stall_c;
  logic [DATA_W-1:0] tag_q, tag_d;
  logic              tag_en;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              rdat_en;

  sem_view_decode u_dec (
    .rd   (acc_rd),
    .wr   (acc_wr),
    .view (acc_view),
    .op   (op)
  );

  sem_count_core #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_req  (op.sem_wr),
    .dec_req  (op.sem_rd_wait | op.sem_rd_poll),
    .cnt      (cnt),
    .cnt_zero (cnt_zero)
  );

  assign stall_c = op.sem_rd_wait & cnt_zero;

  sem_wait_tracker #(.N_REQ(N_REQ), .ID_W(ID_W)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .block_req (stall_c),
    .block_id  (acc_id),
    .wake_req  (op.sem_wr),
    .wake_vec  (wake_vec)
  );

  // tag flags: only E, F and T are storable, queue-mode bit stays zero
  always_comb begin
    tag_en = op.tag_wr;
    tag_d  = acc_wdata & TAG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (tag_en) tag_q <= tag_d;
  end

  // read data register
  always_comb begin
    rdat_en = (op.sem_rd_wait & ~stall_c) | op.sem_rd_poll | op.raw_rd |
              op.tag_rd | op.null_rd;
    if (op.tag_rd)       rdat_d = tag_q;
    else if (op.null_rd) rdat_d = '0;
    else                 rdat_d = DATA_W'(cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdat_q <= '0;
    else if (rdat_en) rdat_q <= rdat_d;
  end

  assign rd_data = rdat_q;
  assign stall   = stall_c;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(cnt) && $stable(rd_data))); // R3
  AST_RAW_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_view == VW_RAW) |=> $stable(cnt)); // R6
  AST_Q_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_q[TAG_Q_BIT]); // R8
  AST_WAKE_SEES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_vec != '0) |-> (cnt != '0)); // R10
  AST_BOTH_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_wr) |-> !stall); // R9

endmodule

// File: tb/sem_cell_tb.sv
module sem_cell_tb_top;

  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int N_REQ  = 8;
  localparam int ID_W   = 3;
  localparam int CMAX   = 65535;

  logic              clk;
  logic              rst_n;
  logic              acc_rd;
  logic              acc_wr;
  logic [2:0]        acc_view;
  logic [ID_W-1:0]   acc_id;
  logic [DATA_W-1:0] acc_wdata;
  logic [DATA_W-1:0] rd_data;
  logic              stall;
  logic [N_REQ-1:0]  wake_vec;

  sem_cell #(.CNT_W(CNT_W), .DATA_W(DATA_W), .N_REQ(N_REQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_view(acc_view), .acc_id(acc_id), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .stall(stall), .wake_vec(wake_vec)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] val;
    string       rq;
  } exp_t;

  exp_t sb_q[$];

  // reference model state
  int          m_cnt  = 0;
  logic [7:0]  m_mask = '0;
  logic [31:0] m_tag  = '0;
  logic [31:0] m_last = '0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  // monitor: compare outputs as results fall due
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      if (e.kind == 0) chk({e.rq, " rd_data"}, rd_data, e.val);
      else             chk({e.rq, " wake_vec"}, {24'h0, wake_vec}, e.val);
    end
  end

  function automatic logic [31:0] exp_read(input logic [2:0] vw);
    case (vw)
      3'd0, 3'd4, 3'd5: return 32'(m_cnt);
      3'd1:             return m_tag;
      default:          return 32'h0;
    endcase
  endfunction

  // driver: one access per cycle, pushes expectations, updates model
  task automatic op(input bit rd, input bit wr, input logic [2:0] vw,
                    input logic [31:0] d, input int id, input string rq);
    bit          exp_stall;
    logic [31:0] wk;
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_view = vw; acc_wdata = d; acc_id = ID_W'(id);
    #1;
    exp_stall = rd && !wr && vw == 3'd4 && m_cnt == 0;
    chk({rq, " stall"}, {31'h0, stall}, {31'h0, exp_stall});
    wk = 32'h0;
    if (wr) begin
      if (vw == 3'd4 || vw == 3'd5) begin
        if (m_cnt < CMAX) m_cnt++;
        wk = {24'h0, m_mask};
        m_mask = '0;
      end else if (vw == 3'd1) begin
        m_tag = d & 32'h0001_0003;
      end
      if (rd) sb_q.push_back('{cyc + 1, 0, m_last, rq});
    end else if (rd) begin
      if (exp_stall) begin
        m_mask[id] = 1'b1;
        sb_q.push_back('{cyc + 1, 0, m_last, rq});
      end else begin
        m_last = exp_read(vw);
        sb_q.push_back('{cyc + 1, 0, m_last, rq});
        if ((vw == 3'd4 || vw == 3'd5) && m_cnt > 0) m_cnt--;
      end
    end
    sb_q.push_back('{cyc + 1, 1, wk, rq});
    @(posedge clk);
    #1;
    acc_rd = 1'b0; acc_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0; acc_view = '0;
    acc_id = '0; acc_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset rd_data", rd_data, 32'h0);
    chk("R7 reset wake", {24'h0, wake_vec}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    op(1, 0, 3'd0, 32'h0, 0, "R7 count zero");
    op(1, 0, 3'd1, 32'h0, 0, "R7 tag zero");
    op(1, 0, 3'd5, 32'h0, 1, "R3 poll at zero");
    op(1, 0, 3'd0, 32'h0, 0, "R2 count held at zero");

    op(0, 1, 3'd4, 32'hDEAD_BEEF, 0, "R4 write data ignored");
    op(0, 1, 3'd5, 32'h0000_0000, 1, "R4 write");
    op(0, 1, 3'd4, 32'hFFFF_FFFF, 2, "R4 write");
    op(1, 0, 3'd0, 32'h0, 0, "R4 count three");
    op(1, 0, 3'd5, 32'h0, 3, "R1 poll pre-value");
    op(1, 0, 3'd4, 32'h0, 3, "R1 wait pre-value");
    op(1, 0, 3'd4, 32'h0, 3, "R1 wait to zero");
    op(1, 0, 3'd0, 32'h0, 0, "R2 count zero");

    op(1, 0, 3'd4, 32'h0, 2, "R3 block id2");
    op(1, 0, 3'd4, 32'h0, 5, "R3 block id5");
    op(1, 0, 3'd0, 32'h0, 0, "R3 count unchanged");
    op(0, 1, 3'd5, 32'h0, 0, "R5 wake two");
    op(1, 0, 3'd4, 32'h0, 2, "R10 retry sees count");
    op(0, 1, 3'd4, 32'h0, 0, "R5 no wake when empty");
    op(1, 0, 3'd0, 32'h0, 0, "R5 wake once then quiet");

    op(0, 1, 3'd0, 32'h0000_1234, 0, "R6 raw write");
    op(1, 0, 3'd0, 32'h0, 0, "R6 raw read unchanged");
    op(0, 1, 3'd3, 32'h0000_0077, 0, "R11 write ignored");
    op(1, 0, 3'd2, 32'h0, 0, "R11 read zero");
    op(1, 0, 3'd7, 32'h0, 0, "R11 read zero");
    op(1, 0, 3'd0, 32'h0, 0, "R11 count unchanged");

    op(0, 1, 3'd1, 32'hFFFF_FFFF, 0, "R8 tag write");
    op(1, 0, 3'd1, 32'h0, 0, "R8 tag read masked");
    op(0, 1, 3'd1, 32'h0001_0001, 0, "R8 tag write");
    op(1, 0, 3'd1, 32'h0, 0, "R8 tag read");
    op(1, 0, 3'd0, 32'h0, 0, "R8 count unchanged");

    op(1, 0, 3'd4, 32'h0, 0, "R9 drain");
    op(1, 1, 3'd4, 32'h0, 0, "R9 write wins at zero");
    op(1, 0, 3'd0, 32'h0, 0, "R9 count one");

    for (int i = 0; i < CMAX + 2; i++) op(0, 1, 3'd5, 32'(i), 0, "R4 fill");
    op(1, 0, 3'd0, 32'h0, 0, "R4 saturated");
    op(1, 0, 3'd5, 32'h0, 0, "R1 read at ceiling");
    op(1, 0, 3'd0, 32'h0, 0, "R2 one below ceiling");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule